// File: doc/BRIEF.md
# Edge-Detecting Status Interrupt Controller

This block watches four status levels from a power-management core: undervoltage, power-up done, thermal shutdown and thermal warning. Each level is passed through a two-flop synchronizer. The synchronized level is shown live in a status register. A change of level is also recorded in a sticky event register, which the host clears by reading it. While any event bit is set, a registered interrupt line is driven high, so software can find out what changed and react.

Each source has its own event bit, and that bit is a two-state machine. In ACK_IDLE the bit reads 0. The transition IDLE_TO_PENDING is taken on a qualifying edge while the hardware enable is high. In ACK_PENDING the bit reads 1. The transition PENDING_TO_IDLE is taken when the hardware enable is low, or when a read of the event address arrives in a cycle that brings no new qualifying edge. The PENDING_HOLD self-loop keeps the bit set when an edge and a clearing read land in the same cycle. The undervoltage, thermal-shutdown and thermal-warning sources react to both edges. The power-up-done source reacts only to its rising edge.

Bit mapping in both registers: bit 0 undervoltage, bit 1 power-up done, bit 2 thermal shutdown, bit 3 thermal warning. Bits 7..4 read as 0.

Top module: `sense_irq_ctrl`

## Requirements
- R1: `status_o[3:0]` shows the sense levels, using the bit mapping above. A change on `sense_i` appears on `status_o` after exactly two rising clock edges. `status_o[7:4]` is always 0.
- R2: After reset, `status_o` is 0x04, `ack_o` is 0x00 and `irq_o` is 0.
- R3: A rising or a falling edge of undervoltage (bit 0), thermal shutdown (bit 2) or thermal warning (bit 3) sets the matching `ack_o` bit. The bit becomes visible one edge after the new level reaches `status_o`.
- R4: The power-up-done event bit (bit 1) is set by a rising edge of that sense only. A falling edge leaves `ack_o` unchanged.
- R5: A cycle with `rd_en` high and `rd_addr` equal to ACK_ADDR (default 0x0B) clears every `ack_o` bit at that edge. A read of any other address changes nothing.
- R6: If a qualifying edge reaches a bit in the same cycle as a clearing read, that bit stays set after the read.
- R7: While `hw_en` is low, `ack_o[3:0]` is held at 0 and edges are ignored. Edges that occurred while `hw_en` was low do not set any bit after `hw_en` returns high.
- R8: `irq_o` equals the OR of `ack_o[3:0]` as it was one clock earlier.
- R9: An `ack_o` bit that is set stays set until it is cleared by a read or by `hw_en` going low, even if further edges arrive. `ack_o[7:4]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Hardware enable; low clears and holds off the event register |
| sense_i | input | 4 | Raw sense levels: [0] undervoltage, [1] power-up done, [2] thermal shutdown, [3] thermal warning |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | 8 | Address of the register being read |
| status_o | output | 8 | Live synchronized sense levels |
| ack_o | output | 8 | Sticky event register, cleared on read |
| irq_o | output | 1 | Interrupt request, high while an event is pending |

## Verification
The assertions assume that `hw_en`, `rd_en` and `rd_addr` are already synchronous to `clk`. They also assume that a read strobe lasts one cycle per access. Only `sense_i` is treated as asynchronous. The bench drives every input on the falling edge and pulses `rd_en` for exactly one cycle. It times each sense change and each read against the known three-edge path from a sense pin to the event bit. This lets it hit the read-and-edge collision on an exact cycle.

// File: rtl/sense_irq_pkg.sv
package sense_irq_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_UV   = 0;
    localparam int SRC_PGD  = 1;
    localparam int SRC_TSD  = 2;
    localparam int SRC_WARN = 3;

    typedef enum logic {
        EDGE_BOTH,
        EDGE_RISE
    } edge_kind_e;

    typedef enum logic {
        ACK_IDLE,
        ACK_PENDING
    } ack_state_e;

    function automatic edge_kind_e src_edge_kind(input int idx);
        return (idx == SRC_PGD) ? EDGE_RISE : EDGE_BOTH;
    endfunction

    function automatic logic src_reset_level(input int idx);
        return (idx == SRC_TSD) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/sense_sync.sv
module sense_sync
    import sense_irq_pkg::*;
#(
    parameter logic       RESET_LVL = 1'b0,
    parameter edge_kind_e KIND      = EDGE_BOTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic evt_o
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_LVL;
            sync_q <= RESET_LVL;
            prev_q <= RESET_LVL;
        end else begin
            meta_q <= raw_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign evt_o = sync_q & ~prev_q;
        end else begin : g_both
            assign evt_o = sync_q ^ prev_q;
        end
    endgenerate

endmodule

// File: rtl/ack_cell.sv
module ack_cell
    import sense_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic hold_off_i,
    output logic pend_o
);

    ack_state_e state_q;
    ack_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: begin
                if (!hold_off_i && evt_i) begin
                    state_d = ACK_PENDING;
                end
            end
            ACK_PENDING: begin
                if (hold_off_i) begin
                    state_d = ACK_IDLE;
                end else if (evt_i) begin
                    state_d = ACK_PENDING;
                end else if (clr_i) begin
                    state_d = ACK_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        pend_o = (state_q == ACK_PENDING);
    end

endmodule

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl
    import sense_irq_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          REG_W    = 8,
    parameter logic [7:0]  ACK_ADDR = 8'h0B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic [3:0]        sense_i,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  status_o,
    output logic [REG_W-1:0]  ack_o,
    output logic              irq_o
);

    localparam int PAD_W = REG_W - NUM_SRC;

    logic [NUM_SRC-1:0] level_w;
    logic [NUM_SRC-1:0] evt_w;
    logic [NUM_SRC-1:0] pend_w;
    logic               clr_hit;
    logic               irq_q;

    assign clr_hit = rd_en && (rd_addr == ADDR_W'(ACK_ADDR));

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            sense_sync #(
                .RESET_LVL (src_reset_level(i)),
                .KIND      (src_edge_kind(i))
            ) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_i   (sense_i[i]),
                .level_o (level_w[i]),
                .evt_o   (evt_w[i])
            );

            ack_cell u_ack (
                .clk        (clk),
                .rst_n      (rst_n),
                .evt_i      (evt_w[i]),
                .clr_i      (clr_hit),
                .hold_off_i (!hw_en),
                .pend_o     (pend_w[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pend_w;
        end
    end

    assign status_o = {{PAD_W{1'b0}}, level_w};
    assign ack_o    = {{PAD_W{1'b0}}, pend_w};
    assign irq_o    = irq_q;

endmodule

// File: rtl/sense_irq_ctrl_chk.sv
module sense_irq_ctrl_chk #(
    parameter logic [7:0] ACK_ADDR = 8'h0B
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_en,
    input logic       rd_en,
    input logic [7:0] rd_addr,
    input logic [7:0] status_o,
    input logic [7:0] ack_o,
    input logic       irq_o
);

    logic rd_hit;
    assign rd_hit = rd_en && (rd_addr == ACK_ADDR);

    // R1 / R9: upper bits of both registers are always zero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:4] == 4'h0) && (ack_o[7:4] == 4'h0));

    // R3: an event bit rises only after its status level changed
    generate
        for (genvar i = 0; i < 4; i++) begin : g_edge
            p_set_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ack_o[i]) |-> ($past(status_o[i]) != $past(status_o[i], 2)));
        end
    endgenerate

    // R4: the power-up-done event bit rises only when its level went high
    p_pgood_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o[1]) |-> $past(status_o[1]));

    // R5 / R6: after a clearing read, only bits with a fresh edge survive
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> ((ack_o[3:0] & ~($past(status_o[3:0]) ^ $past(status_o[3:0], 2))) == 4'h0));

    // R7: a low enable empties the event register
    p_enable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |=> (ack_o[3:0] == 4'h0));

    // R8: the interrupt follows the event register one cycle later
    p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|ack_o[3:0]));

    // R9: pending bits stay set without a clearing read or enable drop
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit && hw_en) |=> ((ack_o[3:0] & $past(ack_o[3:0])) == $past(ack_o[3:0])));

endmodule

bind sense_irq_ctrl sense_irq_ctrl_chk #(.ACK_ADDR(ACK_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_en    (hw_en),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .status_o (status_o),
    .ack_o    (ack_o),
    .irq_o    (irq_o)
);

// File: tb/sim_sense_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sense_irq_ctrl;

    localparam time        CLK_PERIOD = 10ns;
    localparam logic [7:0] ACK_A      = 8'h0B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b1;
    logic [3:0] sense_i = 4'b0100;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] status_o;
    logic [7:0] ack_o;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sense_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sense_i(sense_i),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .status_o(status_o), .ack_o(ack_o), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] data);
        rd_en = 1'b1;
        rd_addr = a;
        #1 data = (a == ACK_A) ? ack_o : status_o;
        tick(1);
        rd_en = 1'b0;
    endtask

    task automatic clear_ack();
        logic [7:0] d;
        read_reg(ACK_A, d);
        tick(2);
    endtask

    task automatic t_reset();
        check(status_o, 8'h04, "R2 status reset");
        check(ack_o, 8'h00, "R2 ack reset");
        check({7'd0, irq_o}, 8'h00, "R2 irq reset");
    endtask

    task automatic t_status_and_irq();
        logic [7:0] d;
        sense_i = 4'b0101;
        tick(1);
        check(status_o, 8'h04, "R1 status not yet synced");
        tick(1);
        check(status_o, 8'h05, "R1 status after two edges");
        tick(1);
        check(ack_o, 8'h01, "R3 uv rising edge");
        check({7'd0, irq_o}, 8'h00, "R8 irq one cycle behind");
        tick(1);
        check({7'd0, irq_o}, 8'h01, "R8 irq raised");
        read_reg(ACK_A, d);
        check(d, 8'h01, "R5 read data");
        check(ack_o, 8'h00, "R5 cleared by read");
        tick(1);
        check({7'd0, irq_o}, 8'h00, "R8 irq dropped");
    endtask

    task automatic t_dual_edges();
        sense_i = 4'b0100;
        tick(3);
        check(ack_o, 8'h01, "R3 uv falling edge");
        clear_ack();
        sense_i = 4'b0000;
        tick(3);
        check(ack_o, 8'h04, "R3 tsd falling edge");
        clear_ack();
        sense_i = 4'b1000;
        tick(3);
        check(ack_o, 8'h08, "R3 warn rising edge");
        sense_i = 4'b0000;
        tick(4);
        check(ack_o, 8'h08, "R9 sticky under new edge");
        clear_ack();
    endtask

    task automatic t_pgood();
        sense_i = 4'b0010;
        tick(3);
        check(ack_o, 8'h02, "R4 pgood rising edge");
        clear_ack();
        sense_i = 4'b0000;
        tick(4);
        check(status_o, 8'h00, "R1 pgood level low");
        check(ack_o, 8'h00, "R4 pgood falling ignored");
        check({7'd0, irq_o}, 8'h00, "R4 no irq on pgood fall");
    endtask

    task automatic t_other_read();
        logic [7:0] d;
        sense_i = 4'b1000;
        tick(3);
        read_reg(8'h0A, d);
        tick(2);
        check(ack_o, 8'h08, "R5 other address no clear");
        clear_ack();
        check(ack_o, 8'h00, "R5 clear after real read");
    endtask

    task automatic t_collision();
        logic [7:0] d;
        sense_i = 4'b0000;
        tick(3);
        sense_i = 4'b0001;
        tick(2);
        read_reg(ACK_A, d);
        check(d, 8'h08, "R6 read data before collision");
        check(ack_o, 8'h01, "R6 coincident edge kept");
        clear_ack();
    endtask

    task automatic t_enable();
        sense_i = 4'b1000;
        tick(3);
        check(ack_o, 8'h09, "R3 two sources pending");
        hw_en = 1'b0;
        tick(1);
        check(ack_o, 8'h00, "R7 enable low clears");
        tick(1);
        check({7'd0, irq_o}, 8'h00, "R7 irq cleared");
        sense_i = 4'b0011;
        tick(4);
        check(status_o, 8'h03, "R1 status live while disabled");
        check(ack_o, 8'h00, "R7 edges ignored while low");
        hw_en = 1'b1;
        tick(4);
        check(ack_o, 8'h00, "R7 no stale events after enable");
        sense_i = 4'b0010;
        tick(3);
        check(ack_o, 8'h01, "R7 events resume");
        clear_ack();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_status_and_irq();
        t_dual_edges();
        t_pgood();
        t_other_read();
        t_collision();
        t_enable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule